// File: doc/BRIEF.md
# Branch and Skip Condition Unit

This unit resolves conditional control flow for a small 8-bit processor core. It handles three kinds of operation. A flag branch tests one bit of the status register against a required polarity and, when the test holds, jumps relative to the current program counter. An unconditional relative jump always jumps. A skip tests either two register values for equality or one bit of a register or I/O value. When a skip is taken, it steps over the next instruction, which is one or two words long.

One clock after a request, the unit presents a taken flag, the next program counter and the number of cycles the operation costs. The sequencer of the core uses these values to redirect fetch and to insert stall cycles. The unit registers its result in a small state register, which records the outcome class: idle, fall-through, relative target taken, skip over one word, or skip over two words. The outputs are decoded from that state.

The states are ST_IDLE, ST_FALL, ST_TAKEN, ST_SKIP_ONE and ST_SKIP_TWO. Every clock the state is reloaded from the current request, so each result lasts exactly one cycle. The transitions are:
- no request, or the no-op code: to ST_IDLE.
- a branch whose test fails, or a skip whose test fails: to ST_FALL.
- a branch whose test holds, or any jump: to ST_TAKEN.
- a skip whose test holds, with a one-word follower: to ST_SKIP_ONE.
- a skip whose test holds, with a two-word follower: to ST_SKIP_TWO.

Top module: `brskip_unit`

## Requirements
- R1: After reset, and in the cycle after any clock edge where `op_valid` is 0 or `op_kind` is 000, the outputs are `res_valid`=0, `taken`=0, `cycles`=0 and `next_pc`=0.
- R2: The `op_kind` codes are: 000 none, 001 flag branch, 010 relative jump, 011 skip if equal, 100 skip if register bit clear, 101 skip if register bit set, 110 skip if I/O bit clear, 111 skip if I/O bit set.
- R3: A flag branch is taken exactly when `sreg[flag_sel]` equals `flag_pol`. The status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R4: A taken branch gives `next_pc` = `pc` + sign-extended `off[BR_OFF_W-1:0]` + 1, modulo 2^PC_W, with `cycles`=2. A branch that is not taken gives `pc`+1 with `cycles`=1.
- R5: For a flag branch, the bits of `off` above `BR_OFF_W-1` have no effect on `next_pc`.
- R6: A relative jump is always taken, with `next_pc` = `pc` + sign-extended `off` (all JMP_OFF_W bits) + 1, modulo 2^PC_W, and `cycles`=2.
- R7: A skip-if-equal is taken exactly when `rd_val` equals `rr_val`.
- R8: A register-bit skip tests `rd_val[bit_sel]`, and taken means the bit is 0 for the clear form or 1 for the set form. The value on `io_val` has no effect on it.
- R9: An I/O-bit skip tests `io_val[bit_sel]` with the same polarity rule. The value on `rd_val` has no effect on it.
- R10: A taken skip gives `next_pc`=`pc`+2 and `cycles`=2 when `next_two_word` is 0, and `pc`+3 and `cycles`=3 when it is 1. A skip that is not taken gives `pc`+1 and `cycles`=1.
- R11: The result appears in the cycle after the request edge, with `res_valid`=1, and lasts one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request present this cycle |
| op_kind | input | 3 | Operation code (see R2) |
| pc | input | PC_W | Address of the current instruction |
| off | input | JMP_OFF_W | Relative offset, two's complement |
| sreg | input | 8 | Status register flags |
| flag_sel | input | 3 | Status bit index tested by a branch |
| flag_pol | input | 1 | Required value of the tested status bit |
| rd_val | input | 8 | First register operand |
| rr_val | input | 8 | Second register operand |
| bit_sel | input | 3 | Bit index for bit skips |
| io_val | input | 8 | Value read from the addressed low I/O register |
| next_two_word | input | 1 | The following instruction is two words long |
| res_valid | output | 1 | A result is present |
| taken | output | 1 | The branch, jump or skip took effect |
| next_pc | output | PC_W | Address from which fetch continues |
| cycles | output | 2 | Cycle cost of the operation (1, 2 or 3) |

## Verification
The bench builds the unit with an 8-bit program counter, a 7-bit branch offset and a 10-bit jump offset. With these values, every program-counter value and every wrap past either end of the address space can be reached in a few hundred requests. Every status byte is swept against all eight flag indices and both polarities, with junk in the upper offset bits. Every register and I/O value is swept against all bit indices, both skip polarities and both follower lengths, while the unused operand is driven to the complement of the tested one.

// File: rtl/brskip_pkg.sv
package brskip_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_BRANCH   = 3'd1,
        OP_JUMP     = 3'd2,
        OP_SKEQ     = 3'd3,
        OP_SKRB_CLR = 3'd4,
        OP_SKRB_SET = 3'd5,
        OP_SKIO_CLR = 3'd6,
        OP_SKIO_SET = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FALL     = 3'd1,
        ST_TAKEN    = 3'd2,
        ST_SKIP_ONE = 3'd3,
        ST_SKIP_TWO = 3'd4
    } state_e;

endpackage

// File: rtl/brskip_cond.sv
module brskip_cond
    import brskip_pkg::*;
(
    input  logic [2:0] op_kind,
    input  logic [7:0] sreg,
    input  logic [2:0] flag_sel,
    input  logic       flag_pol,
    input  logic [7:0] rd_val,
    input  logic [7:0] rr_val,
    input  logic [2:0] bit_sel,
    input  logic [7:0] io_val,
    output logic       is_rel,
    output logic       is_skip,
    output logic       short_off,
    output logic       cond_hit
);

    always_comb begin
        is_rel    = 1'b0;
        is_skip   = 1'b0;
        short_off = 1'b0;
        cond_hit  = 1'b0;
        unique case (op_e'(op_kind))
            OP_NONE: begin
                cond_hit = 1'b0;
            end
            OP_BRANCH: begin
                is_rel    = 1'b1;
                short_off = 1'b1;
                cond_hit  = (sreg[flag_sel] == flag_pol);
            end
            OP_JUMP: begin
                is_rel   = 1'b1;
                cond_hit = 1'b1;
            end
            OP_SKEQ: begin
                is_skip  = 1'b1;
                cond_hit = (rd_val == rr_val);
            end
            OP_SKRB_CLR: begin
                is_skip  = 1'b1;
                cond_hit = ~rd_val[bit_sel];
            end
            OP_SKRB_SET: begin
                is_skip  = 1'b1;
                cond_hit = rd_val[bit_sel];
            end
            OP_SKIO_CLR: begin
                is_skip  = 1'b1;
                cond_hit = ~io_val[bit_sel];
            end
            OP_SKIO_SET: begin
                is_skip  = 1'b1;
                cond_hit = io_val[bit_sel];
            end
        endcase
    end

endmodule

// File: rtl/brskip_target.sv
module brskip_target #(
    parameter int PC_W      = 16,
    parameter int BR_OFF_W  = 7,
    parameter int JMP_OFF_W = 12
) (
    input  logic [PC_W-1:0]      pc,
    input  logic [JMP_OFF_W-1:0] off,
    input  logic                 short_off,
    output logic [PC_W-1:0]      tgt_rel,
    output logic [PC_W-1:0]      pc_p1,
    output logic [PC_W-1:0]      pc_p2,
    output logic [PC_W-1:0]      pc_p3
);

    localparam int EXT_W = (PC_W > JMP_OFF_W) ? PC_W : JMP_OFF_W;

    logic signed [BR_OFF_W-1:0]  br_s;
    logic signed [JMP_OFF_W-1:0] jmp_s;
    logic [EXT_W-1:0]            br_ext;
    logic [EXT_W-1:0]            jmp_ext;
    logic [EXT_W-1:0]            pc_ext;
    logic [EXT_W-1:0]            sum;

    assign br_s    = off[BR_OFF_W-1:0];
    assign jmp_s   = off;
    assign br_ext  = EXT_W'(br_s);
    assign jmp_ext = EXT_W'(jmp_s);
    assign pc_ext  = EXT_W'(pc);

    always_comb begin
        sum = pc_ext + (short_off ? br_ext : jmp_ext) + EXT_W'(1);
    end

    assign tgt_rel = sum[PC_W-1:0];
    assign pc_p1   = pc + PC_W'(1);
    assign pc_p2   = pc + PC_W'(2);
    assign pc_p3   = pc + PC_W'(3);

endmodule

// File: rtl/brskip_unit.sv
module brskip_unit
    import brskip_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int BR_OFF_W  = 7,
    parameter int JMP_OFF_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [2:0]           op_kind,
    input  logic [PC_W-1:0]      pc,
    input  logic [JMP_OFF_W-1:0] off,
    input  logic [7:0]           sreg,
    input  logic [2:0]           flag_sel,
    input  logic                 flag_pol,
    input  logic [7:0]           rd_val,
    input  logic [7:0]           rr_val,
    input  logic [2:0]           bit_sel,
    input  logic [7:0]           io_val,
    input  logic                 next_two_word,
    output logic                 res_valid,
    output logic                 taken,
    output logic [PC_W-1:0]      next_pc,
    output logic [1:0]           cycles
);

    logic            is_rel;
    logic            is_skip;
    logic            short_off;
    logic            cond_hit;
    logic [PC_W-1:0] tgt_rel;
    logic [PC_W-1:0] pc_p1;
    logic [PC_W-1:0] pc_p2;
    logic [PC_W-1:0] pc_p3;
    logic [PC_W-1:0] pc_q;
    state_e          st_q;
    state_e          st_nx;

    brskip_cond i_cond (
        .op_kind  (op_kind),
        .sreg     (sreg),
        .flag_sel (flag_sel),
        .flag_pol (flag_pol),
        .rd_val   (rd_val),
        .rr_val   (rr_val),
        .bit_sel  (bit_sel),
        .io_val   (io_val),
        .is_rel   (is_rel),
        .is_skip  (is_skip),
        .short_off(short_off),
        .cond_hit (cond_hit)
    );

    brskip_target #(
        .PC_W     (PC_W),
        .BR_OFF_W (BR_OFF_W),
        .JMP_OFF_W(JMP_OFF_W)
    ) i_target (
        .pc       (pc),
        .off      (off),
        .short_off(short_off),
        .tgt_rel  (tgt_rel),
        .pc_p1    (pc_p1),
        .pc_p2    (pc_p2),
        .pc_p3    (pc_p3)
    );

    // transition selection
    always_comb begin
        st_nx = ST_IDLE;
        if (op_valid) begin
            if (is_skip) begin
                if (!cond_hit) begin
                    st_nx = ST_FALL;
                end else if (next_two_word) begin
                    st_nx = ST_SKIP_TWO;
                end else begin
                    st_nx = ST_SKIP_ONE;
                end
            end else if (is_rel) begin
                st_nx = cond_hit ? ST_TAKEN : ST_FALL;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // next address register, chosen by the incoming state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            unique case (st_nx)
                ST_IDLE:     pc_q <= '0;
                ST_FALL:     pc_q <= pc_p1;
                ST_TAKEN:    pc_q <= tgt_rel;
                ST_SKIP_ONE: pc_q <= pc_p2;
                ST_SKIP_TWO: pc_q <= pc_p3;
                default:     pc_q <= '0;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        res_valid = 1'b1;
        taken     = 1'b0;
        cycles    = 2'd0;
        unique case (st_q)
            ST_IDLE: begin
                res_valid = 1'b0;
            end
            ST_FALL: begin
                cycles = 2'd1;
            end
            ST_TAKEN: begin
                taken  = 1'b1;
                cycles = 2'd2;
            end
            ST_SKIP_ONE: begin
                taken  = 1'b1;
                cycles = 2'd2;
            end
            ST_SKIP_TWO: begin
                taken  = 1'b1;
                cycles = 2'd3;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end

    assign next_pc = pc_q;

endmodule

// File: rtl/brskip_unit_chk.sv
module brskip_unit_chk #(
    parameter int PC_W      = 16,
    parameter int JMP_OFF_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [2:0]           op_kind,
    input logic [PC_W-1:0]      pc,
    input logic [7:0]           sreg,
    input logic [2:0]           flag_sel,
    input logic                 flag_pol,
    input logic [7:0]           rd_val,
    input logic [7:0]           rr_val,
    input logic [2:0]           bit_sel,
    input logic                 next_two_word,
    input logic                 res_valid,
    input logic                 taken,
    input logic [PC_W-1:0]      next_pc,
    input logic [1:0]           cycles
);

    a_r1_idle_after_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !taken && cycles == 2'd0));

    a_r4_branch_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd1 && sreg[flag_sel] != flag_pol)
        |=> (!taken && cycles == 2'd1 && next_pc == $past(pc) + PC_W'(1)));

    a_r6_jump_always: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd2) |=> (taken && cycles == 2'd2));

    a_r10_skip_two_words: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd3 && rd_val == rr_val && next_two_word)
        |=> (taken && cycles == 2'd3 && next_pc == $past(pc) + PC_W'(3)));

    a_r8_reg_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd5 && rd_val[bit_sel])
        |=> (taken && res_valid));

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != 3'd0) |=> res_valid);

endmodule

bind brskip_unit brskip_unit_chk #(
    .PC_W     (PC_W),
    .JMP_OFF_W(JMP_OFF_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .pc           (pc),
    .sreg         (sreg),
    .flag_sel     (flag_sel),
    .flag_pol     (flag_pol),
    .rd_val       (rd_val),
    .rr_val       (rr_val),
    .bit_sel      (bit_sel),
    .next_two_word(next_two_word),
    .res_valid    (res_valid),
    .taken        (taken),
    .next_pc      (next_pc),
    .cycles       (cycles)
);

// File: tb/test_brskip_unit.sv
`timescale 1ns/1ps
module test_brskip_unit;

    localparam int PC_W      = 8;
    localparam int BR_OFF_W  = 7;
    localparam int JMP_OFF_W = 10;

    localparam logic [2:0] K_NONE = 3'd0;
    localparam logic [2:0] K_BR   = 3'd1;
    localparam logic [2:0] K_JMP  = 3'd2;
    localparam logic [2:0] K_EQ   = 3'd3;
    localparam logic [2:0] K_RBC  = 3'd4;
    localparam logic [2:0] K_RBS  = 3'd5;
    localparam logic [2:0] K_IOC  = 3'd6;
    localparam logic [2:0] K_IOS  = 3'd7;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 op_valid = 1'b0;
    logic [2:0]           op_kind = '0;
    logic [PC_W-1:0]      pc = '0;
    logic [JMP_OFF_W-1:0] off = '0;
    logic [7:0]           sreg = '0;
    logic [2:0]           flag_sel = '0;
    logic                 flag_pol = 1'b0;
    logic [7:0]           rd_val = '0;
    logic [7:0]           rr_val = '0;
    logic [2:0]           bit_sel = '0;
    logic [7:0]           io_val = '0;
    logic                 next_two_word = 1'b0;
    logic                 res_valid;
    logic                 taken;
    logic [PC_W-1:0]      next_pc;
    logic [1:0]           cycles;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brskip_unit #(
        .PC_W     (PC_W),
        .BR_OFF_W (BR_OFF_W),
        .JMP_OFF_W(JMP_OFF_W)
    ) i_brskip_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .pc(pc), .off(off), .sreg(sreg), .flag_sel(flag_sel), .flag_pol(flag_pol),
        .rd_val(rd_val), .rr_val(rr_val), .bit_sel(bit_sel), .io_val(io_val),
        .next_two_word(next_two_word), .res_valid(res_valid), .taken(taken),
        .next_pc(next_pc), .cycles(cycles)
    );

    function automatic int rel_target(int p, int o, int w);
        int s;
        s = o & ((1 << w) - 1);
        if (s >= (1 << (w - 1))) s = s - (1 << w);
        return (p + s + 1) & 255;
    endfunction

    task automatic check(string tag, logic ev, logic et, int epc, int ecy);
        total++;
        if (res_valid !== ev || taken !== et || next_pc !== epc[PC_W-1:0] || cycles !== ecy[1:0]) begin
            bad++;
            $display("FAIL %s: got valid=%0b taken=%0b pc=%0d cyc=%0d, expected valid=%0b taken=%0b pc=%0d cyc=%0d",
                     tag, res_valid, taken, next_pc, cycles, ev, et, epc, ecy);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic skip_expect(string tag, logic hit, int p, logic tw);
        if (!hit) check(tag, 1'b1, 1'b0, (p + 1) & 255, 1);
        else if (tw) check(tag, 1'b1, 1'b1, (p + 3) & 255, 3);
        else check(tag, 1'b1, 1'b1, (p + 2) & 255, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 1'b0, 0, 0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", 1'b0, 1'b0, 0, 0);

        // R3 R4 R5: all flags, polarities and status bytes; junk in upper offset bits
        for (int sel = 0; sel < 8; sel++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int sv = 0; sv < 256; sv++) begin
                    int p;
                    int o;
                    logic hit;
                    p = (sv * 7 + sel * 31) & 255;
                    o = ((sv ^ (sel * 19)) & 127) | (((sv + pol) & 7) << 7);
                    op_valid = 1'b1; op_kind = K_BR; pc = p[7:0]; off = o[9:0];
                    sreg = sv[7:0]; flag_sel = sel[2:0]; flag_pol = pol[0];
                    hit = (((sv >> sel) & 1) == pol);
                    step();
                    if (hit) check("R3 R4 R5 branch taken", 1'b1, 1'b1, rel_target(p, o, BR_OFF_W), 2);
                    else check("R3 R4 branch fall", 1'b1, 1'b0, (p + 1) & 255, 1);
                end
            end
        end

        // R5: upper offset bits alone changed, target unchanged
        for (int hi = 0; hi < 8; hi++) begin
            op_valid = 1'b1; op_kind = K_BR; pc = 8'd250; off = 10'(hi * 128 + 10);
            sreg = 8'h02; flag_sel = 3'd1; flag_pol = 1'b1;
            step();
            check("R5 upper offset ignored", 1'b1, 1'b1, (250 + 10 + 1) & 255, 2);
        end

        // R6: jumps over every pc plus offset extremes
        for (int p = 0; p < 256; p++) begin
            int o;
            o = (p * 37 + 5) & 1023;
            op_valid = 1'b1; op_kind = K_JMP; pc = p[7:0]; off = o[9:0];
            sreg = 8'h00; flag_sel = 3'd0; flag_pol = 1'b1;
            step();
            check("R6 jump", 1'b1, 1'b1, rel_target(p, o, JMP_OFF_W), 2);
        end
        op_valid = 1'b1; op_kind = K_JMP; pc = 8'd255; off = 10'd0;
        step();
        check("R6 jump wrap high", 1'b1, 1'b1, 0, 2);
        pc = 8'd3; off = 10'h200;
        step();
        check("R6 jump most negative", 1'b1, 1'b1, rel_target(3, 512, JMP_OFF_W), 2);
        op_kind = K_BR; pc = 8'd0; off = 10'h040; sreg = 8'hFF; flag_sel = 3'd7; flag_pol = 1'b1;
        step();
        check("R4 branch most negative wrap", 1'b1, 1'b1, (0 - 64 + 1) & 255, 2);

        // R7 R10: equality skips
        for (int a = 0; a < 256; a++) begin
            for (int v = 0; v < 4; v++) begin
                for (int tw = 0; tw < 2; tw++) begin
                    int b;
                    int p;
                    b = (v == 0) ? a : (v == 1) ? (a ^ 1) : (v == 2) ? (a ^ 128) : 0;
                    p = (a * 3 + v * 64 + tw * 200) & 255;
                    op_valid = 1'b1; op_kind = K_EQ; pc = p[7:0];
                    rd_val = a[7:0]; rr_val = b[7:0]; next_two_word = tw[0];
                    step();
                    skip_expect("R7 R10 skip equal", (a == b), p, tw[0]);
                end
            end
        end

        // R8 R9 R10: bit skips on register and I/O values
        for (int kk = 0; kk < 4; kk++) begin
            for (int val = 0; val < 256; val++) begin
                for (int bi = 0; bi < 8; bi++) begin
                    for (int tw = 0; tw < 2; tw++) begin
                        int p;
                        logic bitv;
                        logic hit;
                        logic is_io;
                        logic want_set;
                        is_io = (kk >= 2);
                        want_set = kk[0];
                        p = (val + bi * 33 + tw * 129 + kk * 7) & 255;
                        op_valid = 1'b1;
                        op_kind = (kk == 0) ? K_RBC : (kk == 1) ? K_RBS : (kk == 2) ? K_IOC : K_IOS;
                        pc = p[7:0]; bit_sel = bi[2:0]; next_two_word = tw[0];
                        if (is_io) begin io_val = val[7:0]; rd_val = ~val[7:0]; end
                        else begin rd_val = val[7:0]; io_val = ~val[7:0]; end
                        bitv = ((val >> bi) & 1) == 1;
                        hit = (bitv == want_set);
                        step();
                        if (is_io) skip_expect("R9 R10 io bit skip", hit, p, tw[0]);
                        else skip_expect("R8 R10 reg bit skip", hit, p, tw[0]);
                    end
                end
            end
        end

        // R1 R2 R11: request gaps and the no-op code
        op_valid = 1'b1; op_kind = K_JMP; pc = 8'd10; off = 10'd4;
        step();
        check("R11 result present", 1'b1, 1'b1, 15, 2);
        op_valid = 1'b0;
        step();
        check("R1 R11 result lasts one cycle", 1'b0, 1'b0, 0, 0);
        op_valid = 1'b1; op_kind = K_NONE;
        step();
        check("R1 R2 no-op code", 1'b0, 1'b0, 0, 0);
        op_valid = 1'b0; op_kind = K_EQ; rd_val = 8'd5; rr_val = 8'd5;
        step();
        check("R1 no request ignored", 1'b0, 1'b0, 0, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule